// File: doc/BRIEF.md
# Page-Mode ROM Read Sequencer

This block turns CPU read requests into read cycles on an external memory bus. Each request carries a 24-bit byte address and an access size. One address region, picked by the top address bits, holds a ROM that can run in page mode. When page mode is on, the first read into a page uses a full-length cycle with a programmable number of states. Later reads that follow on sequentially inside the same page use a short cycle whose length comes from a configuration field. Reads to every other region always use a plain cycle with their own length.

The sequencer drives a chip select for the ROM region and a second one for all other regions. It also drives a shared read strobe and the address bus, and it samples the 32-bit data bus on the last state of each cycle. On the CPU side, a request is taken on a valid/ready handshake, and the data comes back with a single-cycle valid pulse. While a page burst is live, the ROM chip select and the read strobe stay asserted between accesses, and only the address moves.

Top module: `page_rom_reader`

## Requirements
- R1: During and after reset, with no request, `req_ready` is 1, `rsp_valid` is 0, and `rom_cs_n`, `aux_cs_n` and `rd_n` are all 1.
- R2: A read whose address bits [23:20] differ from 4'h2 (the ROM region) asserts `aux_cs_n`, never `rom_cs_n`, and lasts `cfg_other_len` states.
- R3: When `cfg_page_en` is 0, every read in the ROM region lasts `cfg_first_len` states.
- R4: The first ROM-region read after reset lasts `cfg_first_len` states.
- R5: A ROM-region read takes a short cycle when all of these hold: page mode is live, the read is in the same page as the previous read, and its address equals the previous address plus the previous size. A short cycle lasts 1, 2 or 3 states for `cfg_burst_len` 00, 01 or 10.
- R6: `cfg_page_sz` sets the page to 64, 32, 16 or 8 bytes for 00, 01, 10 or 11. A sequential read whose address falls into the next page lasts `cfg_first_len` states, and the reads after it are short again.
- R7: A read that is not sequential lasts `cfg_first_len` states, even when it lands in the same page.
- R8: With `cfg_burst_len` = 11, every ROM-region read lasts `cfg_first_len` states.
- R9: Page tracking is cleared by a read to another region or by any clock edge with `cfg_page_en` at 0. The next ROM-region read then lasts `cfg_first_len` states, and `rom_cs_n` is 1 while idle after the clear.
- R10: While a page burst is live, `rom_cs_n` and `rd_n` stay 0 between accesses. `bus_addr` is stable throughout each access, and `rd_n` is 0 in every access state.
- R11: `req_ready` is 0 for exactly the length of an access. `rsp_valid` is a one-cycle pulse in the cycle after the last state. `rsp_data` is the value of `bus_din` in that last state. Size codes 0, 1 and 2/3 mean 1, 2 and 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 1 | Page mode enable for the ROM region |
| cfg_burst_len | input | 2 | In-page short cycle length code |
| cfg_page_sz | input | 2 | Page size code |
| cfg_first_len | input | 4 | States of a full ROM-region cycle |
| cfg_other_len | input | 4 | States of a cycle in other regions |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | 24 | Byte address of the request |
| req_size | input | 2 | Access size code |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 32 | Read data |
| rom_cs_n | output | 1 | ROM region chip select, active low |
| aux_cs_n | output | 1 | Other-region chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | 24 | External address bus |
| bus_din | input | 32 | External data bus |

## Verification
Two things can happen on the same edge: the response pulse of one read and the acceptance of the next. On that edge, the short-or-full decision has to use the address and size of the read that has just finished. The bench provokes this by driving every new request in the cycle where `rsp_valid` is high. It runs sweeps over all page sizes and short-length codes, with address runs that cross page ends. The cycle count of each access is compared with a length computed arithmetically from page arithmetic on the previous address.

// File: rtl/page_rom_reader.sv
module page_rom_reader #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int LW = 4,
  parameter int RSEL_W = 4,
  parameter logic [RSEL_W-1:0] ROM_REGION = 4'h2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_page_en,
  input  logic [1:0]    cfg_burst_len,
  input  logic [1:0]    cfg_page_sz,
  input  logic [LW-1:0] cfg_first_len,
  input  logic [LW-1:0] cfg_other_len,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rom_cs_n,
  output logic          aux_cs_n,
  output logic          rd_n,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din
);

  logic          busy;
  logic          in_rom_q;
  logic          live;
  logic [LW-1:0] cnt;
  logic [AW-1:0] last_addr;
  logic [2:0]    last_bytes;

  wire       accept  = req_valid && !busy;
  wire       hit     = req_addr[AW-1 -: RSEL_W] == ROM_REGION;
  wire       pm_ok   = cfg_page_en && (cfg_burst_len != 2'b11);
  wire [2:0] obits   = 3'd6 - {1'b0, cfg_page_sz};
  wire       same_pg = (req_addr >> obits) == (last_addr >> obits);
  wire       seq     = req_addr == (last_addr + AW'(last_bytes));
  wire       short_ok = pm_ok && hit && live && same_pg && seq;

  wire [2:0] req_bytes = (req_size == 2'd0) ? 3'd1 :
                         (req_size == 2'd1) ? 3'd2 : 3'd4;

  wire [LW-1:0] len_sel = short_ok ? (LW'(cfg_burst_len) + LW'(1)) :
                          hit ? cfg_first_len : cfg_other_len;
  wire [LW-1:0] len_eff = (len_sel == '0) ? LW'(1) : len_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      in_rom_q   <= 1'b0;
      cnt        <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      bus_addr   <= '0;
      last_addr  <= '0;
      last_bytes <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        cnt        <= len_eff - LW'(1);
        bus_addr   <= req_addr;
        in_rom_q   <= hit;
        last_addr  <= req_addr;
        last_bytes <= req_bytes;
      end else if (busy) begin
        if (cnt == '0) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= bus_din;
        end else begin
          cnt <= cnt - LW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      live <= 1'b0;
    else if (!cfg_page_en || (accept && !(hit && pm_ok)))
      live <= 1'b0;
    else if (accept)
      live <= 1'b1;
  end

  assign req_ready = !busy;
  assign rom_cs_n  = !((busy && in_rom_q) || live);
  assign aux_cs_n  = !(busy && !in_rom_q);
  assign rd_n      = !(busy || live);

endmodule

module page_rom_reader_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_page_en,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rom_cs_n,
  input logic          aux_cs_n,
  input logic          rd_n,
  input logic [AW-1:0] bus_addr
);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready)); // R11

  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rd_n); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_addr)); // R10

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> aux_cs_n); // R2

  AST_DISABLE_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(!cfg_page_en)) |-> rom_cs_n); // R9

endmodule

bind page_rom_reader page_rom_reader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rom_cs_n(rom_cs_n), .aux_cs_n(aux_cs_n),
  .rd_n(rd_n), .bus_addr(bus_addr)
);

// File: tb/page_rom_reader_bench.sv
module page_rom_reader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page_en = 1'b0;
  logic [1:0]  cfg_burst_len = 2'd0;
  logic [1:0]  cfg_page_sz = 2'd0;
  logic [3:0]  cfg_first_len = 4'd5;
  logic [3:0]  cfg_other_len = 4'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rom_cs_n, aux_cs_n, rd_n;
  logic [23:0] bus_addr;
  logic [31:0] bus_din;

  int n_cmp = 0;
  int n_bad = 0;

  logic        m_live = 1'b0;
  logic [23:0] m_prev = '0;
  int          m_pbytes = 0;
  string       m_why = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_din = {bus_addr[7:0] ^ 8'h5A, bus_addr};

  page_rom_reader u_page_rom_reader (
    .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en),
    .cfg_burst_len(cfg_burst_len), .cfg_page_sz(cfg_page_sz),
    .cfg_first_len(cfg_first_len), .cfg_other_len(cfg_other_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_cs_n(rom_cs_n), .aux_cs_n(aux_cs_n), .rd_n(rd_n),
    .bus_addr(bus_addr), .bus_din(bus_din)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_track();
    @(negedge clk);
    cfg_page_en = 1'b0;
    m_live = 1'b0;
    m_why = "R9";
    @(negedge clk);
    chk("R9 idle cs after disable", rom_cs_n, 1);
  endtask

  task automatic rd(input logic [23:0] a, input logic [1:0] s);
    int     bytes, n, exp_l, sh;
    logic   in_rom, same, seq, shrt, rd_ok;
    string  tag;
    bytes  = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    in_rom = a[23:20] == 4'h2;
    sh     = 6 - cfg_page_sz;
    same   = (a >> sh) == (m_prev >> sh);
    seq    = a == m_prev + 24'(m_pbytes);
    shrt   = cfg_page_en && cfg_burst_len != 2'b11 && in_rom && m_live && same && seq;
    exp_l  = shrt ? cfg_burst_len + 1 : in_rom ? cfg_first_len : cfg_other_len;
    if (!in_rom) tag = "R2";
    else if (!cfg_page_en) tag = "R3";
    else if (cfg_burst_len == 2'b11) tag = "R8";
    else if (!m_live) tag = m_why;
    else if (!seq) tag = "R7";
    else if (!same) tag = "R6";
    else tag = "R5";
    chk("R11 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    rd_ok = 1'b1;
    while (!rsp_valid && n < 40) begin
      if (rd_n || req_ready) rd_ok = 1'b0;
      if (in_rom ? rom_cs_n : aux_cs_n) rd_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk({tag, " access length"}, n - 1, exp_l);
    chk("R10/R2 strobes during access", rd_ok, 1);
    chk("R11 data", rsp_data, {a[7:0] ^ 8'h5A, a});
    if (!in_rom) m_live = 1'b0;
    else m_live = cfg_page_en && cfg_burst_len != 2'b11;
    chk("R10 cs held between accesses", rom_cs_n, !m_live);
    chk("R10 rd held between accesses", rd_n, !m_live);
    m_prev = a; m_pbytes = bytes;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog R11: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] a;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 strobes in reset", {rom_cs_n, aux_cs_n, rd_n}, 3'b111);
    rst_n = 1'b1;
    cfg_page_en = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {req_ready, rsp_valid, rom_cs_n, aux_cs_n, rd_n}, 5'b10111);

    for (int sz = 0; sz < 4; sz++) begin
      for (int sl = 0; sl < 4; sl++) begin
        clear_track();
        cfg_page_sz = 2'(sz);
        cfg_burst_len = 2'(sl);
        cfg_first_len = (sl == 3) ? 4'd5 : 4'(sl + 2 + (sz & 1));
        cfg_page_en = 1'b1;
        a = 24'h200030 + 24'(4 * sl);
        for (int k = 0; k < 22; k++) begin
          rd(a, 2'd2);
          a = a + 24'd4;
        end
      end
    end

    cfg_page_sz = 2'd3; cfg_burst_len = 2'd1; cfg_first_len = 4'd4;
    clear_track();
    cfg_page_en = 1'b1;
    a = 24'h200101;
    for (int k = 0; k < 12; k++) begin
      rd(a, 2'(k % 2));
      a = a + ((k % 2 == 0) ? 24'd1 : 24'd2);
    end

    rd(24'h200200, 2'd2);
    rd(24'h200204, 2'd2);
    rd(24'h200200, 2'd2);
    rd(24'h20020C, 2'd2);
    rd(24'h200210, 2'd2);

    m_why = "R9";
    rd(24'h5000F0, 2'd2);
    rd(24'h200214, 2'd2);
    rd(24'h200218, 2'd2);
    cfg_other_len = 4'd7;
    rd(24'h000010, 2'd1);
    cfg_other_len = 4'd1;
    rd(24'hF00000, 2'd0);
    rd(24'h20021C, 2'd2);

    clear_track();
    rd(24'h200220, 2'd2);
    rd(24'h200224, 2'd2);
    rd(24'h200228, 2'd2);
    cfg_page_en = 1'b1;
    rd(24'h20022C, 2'd2);
    rd(24'h200230, 2'd2);

    cfg_first_len = 4'd9;
    clear_track();
    cfg_page_en = 1'b1;
    rd(24'h2003F8, 2'd2);
    rd(24'h2003FC, 2'd2);
    rd(24'h200400, 2'd2);
    rd(24'h200404, 2'd2);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule